// File: doc/BRIEF.md
# Four-Channel DAC Serial Register Port

This block is the digital front end of a four-channel converter. It receives 24-bit serial words while an active-low select is held low. Bits arrive MSB first. Data is taken on the rising serial clock edge, and return data changes on the falling edge. Each complete word is decoded as either a register write or a read request.

The block holds the following registers:
- per channel: output code, gain trim, offset trim, clear code, ramp setup and converter control;
- global: main setup and boost-supply setup.

Writes and reads use two separate address maps. A read request is answered one word later: the requested value is shifted out on the return line during the next word, which is usually an idle word. The output codes and the per-channel converter control values drive the rest of the device. A status word taken from an input port can be read back.

All serial inputs are first resynchronised into the system clock domain. The block then works on the edges it detects there.

Top module: `dac_spi_regif`

## Requirements
- R1: Only a word of exactly 24 serial clocks taken while select is low is acted on; a word of any other length changes no register. Bits arrive MSB first: bit 23 is the read flag, bits 20:16 the address and bits 15:0 the data.
- R2: A write to address 0x00+ch (ch 0..3) loads the output code of channel ch, shown on `dac_data_o[ch*16 +: 16]`.
- R3: Writes to 0x08+ch, 0x10+ch and 0x14+ch load gain, offset and clear code of channel ch. These read back at 0x08+ch, 0x0C+ch and 0x10+ch.
- R4: A write to 0x1C+ch is a control write. Data bits 15:13 select the target: 0 ramp setup of ch, 1 main setup, 2 converter control of ch, 3 boost setup. Data bits 12:0 are the value. Codes 4 to 7 change no register. Ramp setup reads back at 0x14+ch, main at 0x19 and boost at 0x1A.
- R5: Converter control of channel ch is shown on `dac_ctrl_o[ch*13 +: 13]` and reads back at 0x04+ch.
- R6: After a word with the read flag set, the following valid word carries the addressed 16-bit value in return bits 15:0, with bits 23:16 zero, MSB first.
- R7: A read of 0x18 returns `status_i` as sampled when select falls for the reply word.
- R8: The idle word 0x1CE000 changes no register.
- R9: After reset all registers are zero and no read is pending. A word without the read flag clears any pending read, so its successor returns all zeros.
- R10: `miso_oe_o` is high only while the resynchronised select is low. `miso_o` is zero while select is high.
- R11: Write addresses outside the map are ignored. Read addresses 0x1B to 0x1F return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Word select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for the serial data out |
| status_i | input | 16 | Status word returned on read address 0x18 |
| dac_data_o | output | 64 | Output codes, 16 bits per channel |
| dac_ctrl_o | output | 52 | Converter control, 13 bits per channel |

## Verification
The register map is exercised with distinct patterns: a different value in each register and channel, with no two alike. Because every value is unique, a reply that picks the wrong register, the wrong channel or the wrong global entry is caught.

Reads are chained back to back, so each reply also shows that the request in the same word is honoured. Writes then reads and idles are interleaved, which separates a pending read that is correctly cleared from one that leaks into a later reply.

Words of 23 and 25 clocks, control codes 4 to 7, unmapped addresses and the status path probe the discard and ignore rules at the ports.

// File: rtl/dac_spi_pkg.sv
package dac_spi_pkg;
  localparam int FRAME_W = 24;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 5;
  localparam int NCH     = 4;
  localparam int CREG_W  = 13;
  localparam int SUB_W   = 3;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  localparam logic [SUB_W-1:0] SUB_SLEW = 3'd0;
  localparam logic [SUB_W-1:0] SUB_MAIN = 3'd1;
  localparam logic [SUB_W-1:0] SUB_CTL  = 3'd2;
  localparam logic [SUB_W-1:0] SUB_BOOST = 3'd3;

  // address group = addr[4:2]
  localparam logic [2:0] WG_DATA = 3'b000;
  localparam logic [2:0] WG_GAIN = 3'b010;
  localparam logic [2:0] WG_OFFS = 3'b100;
  localparam logic [2:0] WG_CLR  = 3'b101;
  localparam logic [2:0] WG_CTRL = 3'b111;

  localparam logic [2:0] RG_DATA = 3'b000;
  localparam logic [2:0] RG_CTL  = 3'b001;
  localparam logic [2:0] RG_GAIN = 3'b010;
  localparam logic [2:0] RG_OFFS = 3'b011;
  localparam logic [2:0] RG_CLR  = 3'b100;
  localparam logic [2:0] RG_SLEW = 3'b101;
  localparam logic [2:0] RG_GLB  = 3'b110;

  typedef struct packed {
    logic              rd;
    logic [1:0]        rsv;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import dac_spi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               cs_ni,
  input  logic               mosi_i,
  input  logic [DATA_W-1:0]  tx_word_i,
  output logic               frm_vld_o,
  output logic [FRAME_W-1:0] frm_o,
  output logic               miso_o,
  output logic               miso_oe_o
);
  localparam int NSYNC = 3;
  localparam logic [NSYNC-1:0] SYNC_RST = 3'b010; // {sclk, cs, mosi}

  logic [NSYNC-1:0] sync1_q, sync2_q, prev_q;
  logic [FRAME_W-1:0] rx_sr_q, tx_sr_q;
  logic [CNT_W-1:0]   bit_cnt_q;
  logic               vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= SYNC_RST;
      sync2_q <= SYNC_RST;
      prev_q  <= SYNC_RST;
    end else begin
      sync1_q <= {sclk_i, cs_ni, mosi_i};
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  logic sel, sclk_rise, sclk_fall, cs_fall, cs_rise;
  assign sel       = ~sync2_q[1];
  assign sclk_rise = sync2_q[2] & ~prev_q[2];
  assign sclk_fall = ~sync2_q[2] & prev_q[2];
  assign cs_fall   = ~sync2_q[1] & prev_q[1];
  assign cs_rise   = sync2_q[1] & ~prev_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sr_q   <= '0;
      bit_cnt_q <= '0;
    end else if (cs_fall) begin
      bit_cnt_q <= '0;
    end else if (sel && sclk_rise) begin
      rx_sr_q <= {rx_sr_q[FRAME_W-2:0], sync2_q[0]};
      if (bit_cnt_q != '1) bit_cnt_q <= bit_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q <= '0;
    end else if (cs_fall) begin
      tx_sr_q <= {{(FRAME_W-DATA_W){1'b0}}, tx_word_i};
    end else if (sel && sclk_fall) begin
      tx_sr_q <= {tx_sr_q[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= cs_rise && (bit_cnt_q == CNT_W'(FRAME_W));
  end

  assign frm_vld_o = vld_q;
  assign frm_o     = rx_sr_q;
  assign miso_o    = sel & tx_sr_q[FRAME_W-1];
  assign miso_oe_o = sel;

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> bit_cnt_q == '0); // R1
  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_vld_o |=> !frm_vld_o); // R1
  AST_VLD_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_vld_o |-> !miso_oe_o && !miso_o); // R10
endmodule

// File: rtl/dac_reg_file.sv
module dac_reg_file
  import dac_spi_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  frm_vld_i,
  input  frame_t                frm_i,
  input  logic [DATA_W-1:0]     status_i,
  output logic [DATA_W-1:0]     rd_word_o,
  output logic [NCH*DATA_W-1:0] dac_data_o,
  output logic [NCH*CREG_W-1:0] dac_ctrl_o
);
  localparam int CH_W = $clog2(NCH);

  logic [DATA_W-1:0] data_q [NCH];
  logic [DATA_W-1:0] gain_q [NCH];
  logic [DATA_W-1:0] offs_q [NCH];
  logic [DATA_W-1:0] clr_q  [NCH];
  logic [CREG_W-1:0] slew_q [NCH];
  logic [CREG_W-1:0] ctl_q  [NCH];
  logic [CREG_W-1:0] main_q, boost_q;
  logic              rd_pend_q;
  logic [ADDR_W-1:0] rd_addr_q;

  logic              wr;
  logic [CH_W-1:0]   wch;
  logic [2:0]        wgrp;
  logic [SUB_W-1:0]  sub;
  logic [CREG_W-1:0] cval;
  logic              unused_rsv;

  assign wr   = frm_vld_i & ~frm_i.rd;
  assign wch  = frm_i.addr[CH_W-1:0];
  assign wgrp = frm_i.addr[ADDR_W-1:CH_W];
  assign sub  = frm_i.data[DATA_W-1 -: SUB_W];
  assign cval = frm_i.data[CREG_W-1:0];
  assign unused_rsv = ^frm_i.rsv;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = wr && (wch == CH_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g] <= '0;
        gain_q[g] <= '0;
        offs_q[g] <= '0;
        clr_q[g]  <= '0;
        slew_q[g] <= '0;
        ctl_q[g]  <= '0;
      end else if (hit) begin
        case (wgrp)
          WG_DATA: data_q[g] <= frm_i.data;
          WG_GAIN: gain_q[g] <= frm_i.data;
          WG_OFFS: offs_q[g] <= frm_i.data;
          WG_CLR:  clr_q[g]  <= frm_i.data;
          WG_CTRL: begin
            if (sub == SUB_SLEW) slew_q[g] <= cval;
            if (sub == SUB_CTL)  ctl_q[g]  <= cval;
          end
          default: ;
        endcase
      end
    end
    assign dac_data_o[g*DATA_W +: DATA_W] = data_q[g];
    assign dac_ctrl_o[g*CREG_W +: CREG_W] = ctl_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q  <= '0;
      boost_q <= '0;
    end else if (wr && wgrp == WG_CTRL) begin
      if (sub == SUB_MAIN)  main_q  <= cval;
      if (sub == SUB_BOOST) boost_q <= cval;
    end
  end

  // read request is served by the next valid frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
    end else if (frm_vld_i) begin
      rd_pend_q <= frm_i.rd;
      rd_addr_q <= frm_i.addr;
    end
  end

  logic [CH_W-1:0]   rch;
  logic [2:0]        rgrp;
  logic [DATA_W-1:0] rd_mux;
  assign rch  = rd_addr_q[CH_W-1:0];
  assign rgrp = rd_addr_q[ADDR_W-1:CH_W];

  always_comb begin
    rd_mux = '0;
    case (rgrp)
      RG_DATA: rd_mux = data_q[rch];
      RG_CTL:  rd_mux = DATA_W'(ctl_q[rch]);
      RG_GAIN: rd_mux = gain_q[rch];
      RG_OFFS: rd_mux = offs_q[rch];
      RG_CLR:  rd_mux = clr_q[rch];
      RG_SLEW: rd_mux = DATA_W'(slew_q[rch]);
      RG_GLB: begin
        case (rch)
          2'd0:    rd_mux = status_i;
          2'd1:    rd_mux = DATA_W'(main_q);
          2'd2:    rd_mux = DATA_W'(boost_q);
          default: rd_mux = '0;
        endcase
      end
      default: rd_mux = '0;
    endcase
  end

  assign rd_word_o = rd_pend_q ? rd_mux : '0;

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_vld_i |=> $stable(dac_data_o)); // R1
  AST_PEND_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_pend_q) |-> $past(frm_vld_i && frm_i.rd)); // R6
  AST_PEND_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && !frm_i.rd) |=> rd_word_o == '0); // R9
  AST_SUB_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && frm_i.data[DATA_W-1]) |=> $stable(dac_ctrl_o)); // R4
  AST_RD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && frm_i.rd) |=> $stable(dac_data_o)); // R11
endmodule

// File: rtl/dac_spi_regif.sv
module dac_spi_regif
  import dac_spi_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_i,
  input  logic                  cs_ni,
  input  logic                  mosi_i,
  output logic                  miso_o,
  output logic                  miso_oe_o,
  input  logic [DATA_W-1:0]     status_i,
  output logic [NCH*DATA_W-1:0] dac_data_o,
  output logic [NCH*CREG_W-1:0] dac_ctrl_o
);
  logic               frm_vld;
  logic [FRAME_W-1:0] frm_raw;
  logic [DATA_W-1:0]  rd_word;
  frame_t             frm;

  assign frm = frame_t'(frm_raw);

  spi_frame_rx u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_i    (sclk_i),
    .cs_ni     (cs_ni),
    .mosi_i    (mosi_i),
    .tx_word_i (rd_word),
    .frm_vld_o (frm_vld),
    .frm_o     (frm_raw),
    .miso_o    (miso_o),
    .miso_oe_o (miso_oe_o)
  );

  dac_reg_file u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frm_vld_i  (frm_vld),
    .frm_i      (frm),
    .status_i   (status_i),
    .rd_word_o  (rd_word),
    .dac_data_o (dac_data_o),
    .dac_ctrl_o (dac_ctrl_o)
  );
endmodule

// File: tb/tb_dac_spi_regif.sv
module tb_dac_spi_regif;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;

  typedef struct packed {
    logic [23:0] frm;
    logic [15:0] exp;
    logic        chk;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{24'h001234, 16'h0000, 1'b1}, // R9 reset: no pending read
    '{24'h03BEEF, 16'h0000, 1'b0},
    '{24'h0A5A5A, 16'h0000, 1'b0},
    '{24'h11C3C3, 16'h0000, 1'b0},
    '{24'h170FF0, 16'h0000, 1'b0},
    '{24'h1D41F8, 16'h0000, 1'b0},
    '{24'h1E1005, 16'h0000, 1'b0},
    '{24'h1C2ABC, 16'h0000, 1'b0},
    '{24'h1F6055, 16'h0000, 1'b0},
    '{24'h830000, 16'h0000, 1'b1}, // R9 write before
    '{24'h8A0000, 16'hBEEF, 1'b1}, // R6 data ch3
    '{24'h8D0000, 16'h5A5A, 1'b1}, // R3 gain ch2
    '{24'h930000, 16'hC3C3, 1'b1}, // R3 offset ch1
    '{24'h850000, 16'h0FF0, 1'b1}, // R3 clear ch3
    '{24'h960000, 16'h01F8, 1'b1}, // R5 ctrl ch1
    '{24'h990000, 16'h1005, 1'b1}, // R4 slew ch2
    '{24'h9A0000, 16'h0ABC, 1'b1}, // R4 main
    '{24'h1CE000, 16'h0055, 1'b1}, // R4 boost
    '{24'h1CE000, 16'h0000, 1'b1}, // R9 idle clears pending
    '{24'h1D8123, 16'h0000, 1'b1}, // R4 code 4 write
    '{24'h850000, 16'h0000, 1'b1},
    '{24'h1CE000, 16'h01F8, 1'b1}, // R4 code 4 ignored
    '{24'h800000, 16'h0000, 1'b1},
    '{24'h1CE000, 16'h1234, 1'b1}, // R8 idle words left data intact
    '{24'h9B0000, 16'h0000, 1'b1},
    '{24'h1CE000, 16'h0000, 1'b1}, // R11 unmapped read
    '{24'h04FFFF, 16'h0000, 1'b1}, // R11 unmapped write
    '{24'h1CE000, 16'h0000, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        miso, miso_oe;
  logic [15:0] status = '0;
  logic [63:0] dac_data;
  logic [51:0] dac_ctrl;
  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dac_spi_regif dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sclk_i     (sclk),
    .cs_ni      (cs_n),
    .mosi_i     (mosi),
    .miso_o     (miso),
    .miso_oe_o  (miso_oe),
    .status_i   (status),
    .dac_data_o (dac_data),
    .dac_ctrl_o (dac_ctrl)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [23:0] f, input int nbits, output logic [23:0] rx);
    logic [31:0] sh;
    sh = {f, 8'h00};
    rx = '0;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = sh[31];
      sh = sh << 1;
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      rx = {rx[22:0], miso};
      sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2*HALF);
  endtask

  initial begin
    #(CLK_P*150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] rx;
    wait_clk(5);
    check("R9 reset data", dac_data, 64'h0);
    check("R9 reset ctrl", {12'h0, dac_ctrl}, 64'h0);
    check("R10 reset oe", miso_oe, 0);
    rst_n = 1'b1;
    wait_clk(5);

    for (int k = 0; k < NV; k++) begin
      send(VEC[k].frm, 24, rx);
      if (VEC[k].chk) check($sformatf("R6 vector %0d", k), rx, {8'h00, VEC[k].exp});
    end

    check("R2 output codes", dac_data, {16'hBEEF, 16'h0000, 16'h0000, 16'h1234});
    check("R5 ctrl outputs", {12'h0, dac_ctrl}, {12'h0, 52'h1F8 << 13});

    send(24'h00FFFF, 23, rx);
    check("R1 short word discarded", dac_data[15:0], 16'h1234);
    send(24'h00FFFF, 25, rx);
    check("R1 long word discarded", dac_data[15:0], 16'h1234);
    send(24'h02ABCD, 24, rx);
    check("R2 data ch2", dac_data[47:32], 16'hABCD);
    check("R1 other channels kept", {dac_data[63:48], dac_data[31:0]}, {16'hBEEF, 32'h00001234});

    status = 16'hA5C3;
    send(24'h980000, 24, rx);
    send(24'h1CE000, 24, rx);
    check("R7 status read", rx, 24'h00A5C3);

    send(24'h1C6000, 24, rx);
    send(24'h9A0000, 24, rx);
    send(24'h1CE000, 24, rx);
    check("R4 boost rewritten", rx, 24'h000000);

    cs_n = 1'b0;
    wait_clk(2*HALF);
    check("R10 oe while selected", miso_oe, 1);
    cs_n = 1'b1;
    wait_clk(2*HALF);
    check("R10 oe idle", {miso_oe, miso}, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule